// File: doc/BRIEF.md
# Auto-Negotiation Link Pulse Burst Generator

This block produces the repeating pulse bursts that an Ethernet PHY sends on its transmit pair during auto-negotiation. Each burst is a train of seventeen evenly spaced timing pulses. In each of the sixteen gaps between them, an optional extra pulse carries one bit of a 16-bit link code word. The single-bit output is meant to drive the analog line driver. A one-cycle strobe marks the first cycle of every burst, so that a supervising state machine can count bursts.

All intervals are given in nanoseconds and converted to clock cycles from a clock-frequency parameter when the block is built. At default settings the burst period is 16 ms, the timing-pulse spacing is 136 µs, the data slot begins 69 µs after its timing pulse, and every pulse is 100 ns wide. The code word is captured only when a burst starts. Dropping the enable never cuts a burst short: the burst in progress is finished, and no further burst starts.

Top module: `flp_burst_gen`

## Requirements
- R1: Every burst has 17 timing pulses. Timing pulse k (k = 0..16) starts k*SP cycles after the first cycle of the burst, where SP is the rounded spacing in cycles.
- R2: For k = 0..15, a data pulse starts k*SP + DO cycles after the burst start when bit k of the captured code word is 1, and no pulse appears there when the bit is 0. Bit 0 is sent first. A burst therefore holds 17 plus the number of one bits, from 17 to 33 pulses.
- R3: While enable stays high, bursts start exactly PERIOD cycles apart. When enable is raised while the block is idle, the strobe and the first pulse appear in the second cycle after the cycle in which enable was first sampled high.
- R4: Every pulse is high for exactly PW cycles. PW, DO, SP and PERIOD each equal the matching nanosecond value times the clock rate, rounded to the nearest whole cycle, with a minimum of one cycle.
- R5: The code word is sampled only in the cycle a burst starts. A change to it during a burst does not alter that burst.
- R6: When enable is low, a burst already under way completes unchanged. After that the output and the strobe stay low, and no new burst begins until enable returns.
- R7: burst_start is high for one cycle per burst, in the same cycle as the first cycle of timing pulse 0.
- R8: rst_n is synchronous and active low. In the cycle after a clock edge with rst_n low, line_pulse and burst_start are low and all counters are cleared. If enable is high when rst_n is released, a new burst appears in the second cycle after release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | Allows new bursts to start |
| code_word | input | CODE_BITS (16) | Link code word, captured at burst start |
| line_pulse | output | 1 | Registered pulse output to the line driver |
| burst_start | output | 1 | One-cycle strobe on the first cycle of each burst |

## Verification
Two events share the burst-start cycle: the wrap of the period timer and the capture of the code word. A mistimed capture would therefore leak a new word into a burst that is already running. The bench changes the code word about 100 cycles into every burst. It then compares every cycle of that burst against a model built from the old word, and every cycle of the next burst against the new word. Dropping enable, and asserting reset, in the middle of a burst are judged the same way: the remaining waveform, the silence that follows, and the cycle in which the next strobe appears are all checked.

// File: rtl/flp_pkg.sv
// Shared helpers for the link pulse burst generator.
// Assumes nanosecond values and clock rates small enough that their
// product fits in 64 bits.
package flp_pkg;

    // Converts a duration in ns to whole clock cycles, rounding to nearest, minimum 1.
    function automatic longint ns_to_cycles(input longint dur_ns, input longint clk_hz);
        longint cyc;
        cyc = (dur_ns * clk_hz + 64'd500_000_000) / 64'd1_000_000_000;
        if (cyc < 1) cyc = 1;
        return cyc;
    endfunction

endpackage

// File: rtl/flp_period_timer.sv
// Burst period timer. It counts PERIOD_CYC cycles from each burst start
// and issues a start request once it is back at zero with enable high.
// Assumes PERIOD_CYC >= 2. Once started, the count always runs to the
// end of its period, even if enable drops.
module flp_period_timer #(
    parameter int PERIOD_CYC = 2_000_000,
    parameter int CNT_W      = $clog2(PERIOD_CYC)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    output logic start
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(PERIOD_CYC - 1);

    logic [CNT_W-1:0] cnt;

    // A new burst may begin only from the idle count.
    assign start = (cnt == '0) && enable;

    // Advance through one full period after each start, then rest at zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (cnt != '0 || start) begin
            cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
        end
    end

    // R6: an idle timer with enable low stays idle
    a_r6_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == '0 && !enable) |=> (cnt == '0));

    // R3: the period ends exactly at the last count
    a_r3_period_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == LAST) |=> (cnt == '0));

endmodule

// File: rtl/flp_burst_sequencer.sv
// Burst sequencer. On a start request it captures the code word, then
// walks CODE_BITS+1 slots of SP_CYC cycles each. Its combinational
// outputs request a timing pulse at the head of each slot, and a data
// pulse DO_CYC into each slot whose bit is 1. The final slot lasts only
// long enough for its timing pulse.
// Assumes PW_CYC < DO_CYC and DO_CYC + PW_CYC <= SP_CYC.
module flp_burst_sequencer #(
    parameter int CODE_BITS = 16,
    parameter int SP_CYC    = 17_000,
    parameter int DO_CYC    = 8_625,
    parameter int PW_CYC    = 13
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic [CODE_BITS-1:0] code_word,
    output logic                 pulse_req,
    output logic                 first_req
);
    localparam int SLOT_W = $clog2(SP_CYC);
    localparam int IDX_W  = $clog2(CODE_BITS + 1);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(CODE_BITS);

    logic                 active;
    logic [IDX_W-1:0]     idx;
    logic [SLOT_W-1:0]    slot;
    logic [CODE_BITS-1:0] word_q;
    logic [CODE_BITS:0]   word_ext;
    logic                 in_clock, in_data;

    assign word_ext = {1'b0, word_q};

    // Step the slot and bit counters through one burst.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= 1'b0;
            idx    <= '0;
            slot   <= '0;
            word_q <= '0;
        end else if (start) begin
            active <= 1'b1;
            idx    <= '0;
            slot   <= '0;
            word_q <= code_word;
        end else if (active) begin
            if (idx == LAST_IDX && int'(slot) == PW_CYC - 1) begin
                active <= 1'b0;
                idx    <= '0;
                slot   <= '0;
            end else if (int'(slot) == SP_CYC - 1) begin
                slot <= '0;
                idx  <= idx + 1'b1;
            end else begin
                slot <= slot + 1'b1;
            end
        end
    end

    // Decode the slot position into timing-pulse and data-pulse windows.
    always_comb begin
        in_clock  = int'(slot) < PW_CYC;
        in_data   = (idx != LAST_IDX) && word_ext[idx] &&
                    int'(slot) >= DO_CYC && int'(slot) < DO_CYC + PW_CYC;
        pulse_req = active && (in_clock || in_data);
        first_req = active && idx == '0 && slot == '0;
    end

    // R5: a start request never lands inside a running burst
    a_r5_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> !active);

    // R5: the captured word holds while a burst runs
    a_r5_word_held: assert property (@(posedge clk) disable iff (!rst_n)
        (active && !start) |=> $stable(word_q));

    // R1: the slot counter stays inside one spacing interval
    a_r1_slot_bound: assert property (@(posedge clk) disable iff (!rst_n)
        active |-> (int'(slot) < SP_CYC && idx <= LAST_IDX));

endmodule

// File: rtl/flp_pulse_shaper.sv
// Output stage. It registers the pulse and burst-start requests, so the
// line driver sees a glitch-free signal, and it keeps the strobe aligned
// with the first timing pulse. It adds one cycle of latency to both.
module flp_pulse_shaper #(
    parameter int PW_CYC = 13
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pulse_req,
    input  logic first_req,
    output logic line_pulse,
    output logic burst_start
);
    // Register both outputs from the same decode stage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            line_pulse  <= 1'b0;
            burst_start <= 1'b0;
        end else begin
            line_pulse  <= pulse_req;
            burst_start <= first_req;
        end
    end

    // R7: the strobe lasts one cycle
    a_r7_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
        burst_start |=> !burst_start);

    // R7: the strobe coincides with a timing pulse
    a_r7_strobe_on_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        burst_start |-> line_pulse);

    // R4: a pulse wider than one cycle does not collapse after its first cycle
    a_r4_min_width: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(line_pulse) && PW_CYC > 1) |=> line_pulse);

    // R8: a reset edge leaves both outputs low
    a_r8_reset_low: assert property (@(posedge clk)
        !rst_n |=> (!line_pulse && !burst_start));

endmodule

// File: rtl/flp_burst_gen.sv
// Top level of the auto-negotiation link pulse burst generator. It
// converts the nanosecond parameters to cycle counts and connects the
// period timer, the burst sequencer and the output stage.
// Assumes the burst period is longer than 16 spacings plus one pulse.
module flp_burst_gen #(
    parameter int CLK_HZ           = 125_000_000,
    parameter int BURST_PERIOD_NS  = 16_000_000,
    parameter int CLOCK_SPACING_NS = 136_000,
    parameter int DATA_OFFSET_NS   = 69_000,
    parameter int PULSE_NS         = 100,
    parameter int CODE_BITS        = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 enable,
    input  logic [CODE_BITS-1:0] code_word,
    output logic                 line_pulse,
    output logic                 burst_start
);
    localparam longint HZ = longint'(CLK_HZ);
    localparam int PERIOD_CYC = int'(flp_pkg::ns_to_cycles(longint'(BURST_PERIOD_NS), HZ));
    localparam int SP_CYC     = int'(flp_pkg::ns_to_cycles(longint'(CLOCK_SPACING_NS), HZ));
    localparam int DO_CYC     = int'(flp_pkg::ns_to_cycles(longint'(DATA_OFFSET_NS), HZ));
    localparam int PW_CYC     = int'(flp_pkg::ns_to_cycles(longint'(PULSE_NS), HZ));

    logic start, pulse_req, first_req;

    flp_period_timer #(
        .PERIOD_CYC(PERIOD_CYC)
    ) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .enable (enable),
        .start  (start)
    );

    flp_burst_sequencer #(
        .CODE_BITS(CODE_BITS),
        .SP_CYC   (SP_CYC),
        .DO_CYC   (DO_CYC),
        .PW_CYC   (PW_CYC)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .code_word (code_word),
        .pulse_req (pulse_req),
        .first_req (first_req)
    );

    flp_pulse_shaper #(
        .PW_CYC(PW_CYC)
    ) u_out (
        .clk         (clk),
        .rst_n       (rst_n),
        .pulse_req   (pulse_req),
        .first_req   (first_req),
        .line_pulse  (line_pulse),
        .burst_start (burst_start)
    );

    // R6: with enable low and no burst under way, the output stays low
    a_r6_quiet_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        (!enable && !pulse_req && !first_req) |=> !line_pulse);

endmodule

// File: tb/tb_flp_burst_gen.sv
`timescale 1ns/1ps
// Bench for flp_burst_gen. The timing parameters are scaled so that a
// burst period lasts 1000 cycles of the 250 MHz clock.
module tb_flp_burst_gen;
    // R4 rounding at 250 MHz: 10 ns -> 2.5 -> 3, 82 ns -> 20.5 -> 21,
    // 160 ns -> 40, 4000 ns -> 1000.
    localparam int PW  = 3;
    localparam int DO  = 21;
    localparam int SP  = 40;
    localparam int PER = 1000;
    localparam int NV  = 6;

    localparam logic [15:0] VEC_WORD [NV] = '{16'h0000, 16'hFFFF, 16'h0001,
                                              16'h8000, 16'hA5A5, 16'h0E38};
    localparam int          VEC_CNT  [NV] = '{17, 33, 18, 18, 25, 23};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enable = 1'b0;
    logic [15:0] code_word = 16'h0000;
    logic        line_pulse, burst_start;
    int          checks = 0;
    int          fails = 0;
    bit          done = 1'b0;

    always #2 clk = ~clk;

    flp_burst_gen #(
        .CLK_HZ          (250_000_000),
        .BURST_PERIOD_NS (4000),
        .CLOCK_SPACING_NS(160),
        .DATA_OFFSET_NS  (82),
        .PULSE_NS        (10),
        .CODE_BITS       (16)
    ) dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable     (enable),
        .code_word  (code_word),
        .line_pulse (line_pulse),
        .burst_start(burst_start)
    );

    // Expected line level at a given offset from the burst start, per R1, R2 and R4.
    function automatic logic model(input logic [15:0] w, input int off);
        for (int k = 0; k <= 16; k++) begin
            if (off >= k*SP && off < k*SP + PW) return 1'b1;
            if (k < 16 && w[k] && off >= k*SP + DO && off < k*SP + DO + PW) return 1'b1;
        end
        return 1'b0;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Entered at the negedge where the strobe shows (offset 0). Follows one
    // whole period, loads nxt at offset 100, drops enable at dis_at when it
    // is not negative.
    task automatic run_burst(input logic [15:0] w, input logic [15:0] nxt,
                             input int exp_cnt, input int dis_at, input bit chk_period);
        int mism = 0, first_bad = -1, npulse = 0, sbad = 0;
        logic prev = 1'b0;
        logic got_bad = 1'b0;
        for (int off = 0; off < PER; off++) begin
            if (off > 0) @(negedge clk);
            if (line_pulse !== model(w, off)) begin
                if (mism == 0) begin
                    first_bad = off;
                    got_bad = line_pulse;
                end
                mism++;
            end
            if (line_pulse && !prev) npulse++;
            prev = line_pulse;
            if (burst_start !== (off == 0)) sbad++;
            if (off == 100) code_word = nxt;
            if (off == dis_at) enable = 1'b0;
        end
        // R1 R2 R4 R5 R6: whole waveform of the burst against the old word
        check(mism == 0, $sformatf("R1/R2/R4/R5/R6 waveform word %h at offset %0d", w, first_bad),
              int'(got_bad), int'(!got_bad));
        check(npulse == exp_cnt, $sformatf("R2 pulse count word %h", w), npulse, exp_cnt);
        check(sbad == 0, "R7 strobe only at burst start", sbad, 0);
        if (chk_period) begin
            @(negedge clk);
            check(burst_start === 1'b1, "R3 next burst after exactly one period",
                  int'(burst_start), 1);
        end
    endtask

    initial begin
        int quiet;
        repeat (4) @(negedge clk);
        check(line_pulse === 1'b0, "R8 reset line low", int'(line_pulse), 0);
        check(burst_start === 1'b0, "R8 reset strobe low", int'(burst_start), 0);
        rst_n = 1'b1;
        code_word = VEC_WORD[0];
        repeat (5) @(negedge clk);
        check(line_pulse === 1'b0, "R6 idle with enable low", int'(line_pulse), 0);

        enable = 1'b1;
        @(negedge clk);
        check(burst_start === 1'b0, "R3 no strobe one cycle after enable", int'(burst_start), 0);
        @(negedge clk);
        check(burst_start === 1'b1, "R3 strobe two cycles after enable", int'(burst_start), 1);

        // Table of code words, one burst each, next word loaded mid-burst.
        for (int i = 0; i < NV; i++) begin
            run_burst(VEC_WORD[i], (i + 1 < NV) ? VEC_WORD[i+1] : 16'h0F0F,
                      VEC_CNT[i], -1, 1'b1);
        end

        // R6: drop enable mid-burst; the burst completes, then silence.
        run_burst(16'h0F0F, 16'h0F0F, 25, 50, 1'b0);
        quiet = 0;
        for (int c = 0; c < 3*PER; c++) begin
            @(negedge clk);
            if (line_pulse || burst_start) quiet++;
        end
        check(quiet == 0, "R6 no output while disabled", quiet, 0);

        // R3: re-enable from idle.
        enable = 1'b1;
        @(negedge clk);
        @(negedge clk);
        check(burst_start === 1'b1, "R3 restart after re-enable", int'(burst_start), 1);

        // R8: reset in the middle of a burst with enable held high.
        repeat (30) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check(line_pulse === 1'b0 && burst_start === 1'b0, "R8 outputs cleared mid-burst",
              int'(line_pulse), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(burst_start === 1'b0, "R8 no strobe one cycle after release", int'(burst_start), 0);
        @(negedge clk);
        check(burst_start === 1'b1, "R8 burst restarts after release", int'(burst_start), 1);
        run_burst(16'h0F0F, 16'h1234, 25, -1, 1'b1);
        run_burst(16'h1234, 16'h1234, 22, -1, 1'b0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (200_000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

endmodule